// File: doc/BRIEF.md
# Half-to-Single Precision Widener

This block takes one IEEE-754 binary16 operand per clock and produces the binary32 word with exactly the same value. No rounding is needed, because every binary16 value fits in binary32 without loss. Each class of input is handled: normal numbers, subnormals, signed zeros, infinities and NaNs.

Subnormal half-precision inputs become normal single-precision numbers. A combinational priority encoder finds the highest set bit of the mantissa. The mantissa is shifted left until that bit leaves the field, and the exponent is reduced by the same amount. NaNs keep their payload and are always made quiet.

The result is registered. A valid strobe goes with the operand and comes out one cycle later, together with the result of that operand. A synchronous active-high reset clears the output stage.

Top module: `fpw_half_widen`

## Requirements
- R1: For an input exponent field (bits 14:10) from 1 to 30, the output exponent field (bits 30:23) is the input exponent field plus 112. The output fraction (bits 22:0) is the 10-bit input mantissa (bits 9:0) in bits 22:13, with zeros in bits 12:0.
- R2: Output bit 31 equals input bit 15 for every class of input.
- R3: An input exponent field of 31 with a nonzero mantissa gives an output exponent field of 255. Output bit 22 is forced to 1, and output bits 21:13 equal input mantissa bits 8:0. Output bits 12:0 are zero.
- R4: An input exponent field of 31 with a zero mantissa gives an infinity: output bits 30:0 equal 0x7F800000.
- R5: An input with bits 14:0 all zero gives an output with bits 30:0 all zero.
- R6: Take an input with a zero exponent field and a nonzero mantissa m, and let k be the index of the highest set bit of m (0 to 9). The output exponent field is 103 + k, and the output fraction is (m - 2^k) shifted left by 23 - k.
- R7: out_valid equals the in_valid of the previous cycle. When out_valid is 1, out_word is the result for the in_half presented with that in_valid.
- R8: In a cycle where in_valid is 0, out_word keeps its previous value in the next cycle, whatever in_half carries.
- R9: With rst high at a clock edge, out_valid becomes 0 and out_word becomes 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand on in_half is valid this cycle |
| in_half | input | 16 | binary16 operand |
| out_valid | output | 1 | out_word holds a fresh result |
| out_word | output | 32 | binary32 result |

## Verification
The bench builds the block with its default widths: a 5-bit exponent and 10-bit mantissa in, and an 8-bit exponent and 23-bit fraction out. With these widths the full input space is only 65536 codes, so every encoding is driven back to back, both signs of every class included. Every one of the 1023 subnormal mantissas and every NaN payload is checked against a reference computed from the numeric value. Idle gaps in the stream and a reset during traffic cover the hold and clear behaviour.

// File: rtl/fpw_pkg.sv
`timescale 1ns/1ps
package fpw_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUBN = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } fpw_class_e;
endpackage

// File: rtl/fpw_unpack.sv
`timescale 1ns/1ps
module fpw_unpack
  import fpw_pkg::*;
#(
  parameter int EXP_IN = 5,
  parameter int MAN_IN = 10,
  localparam int IN_W  = 1 + EXP_IN + MAN_IN
) (
  input  logic [IN_W-1:0]   word,
  output logic              sign,
  output logic [EXP_IN-1:0] exp_f,
  output logic [MAN_IN-1:0] man_f,
  output fpw_class_e        cls
);
  logic exp_zero;
  logic exp_ones;
  logic man_zero;

  assign sign     = word[IN_W-1];
  assign exp_f    = word[IN_W-2 -: EXP_IN];
  assign man_f    = word[MAN_IN-1:0];
  assign exp_zero = (exp_f == '0);
  assign exp_ones = (exp_f == '1);
  assign man_zero = (man_f == '0);

  always_comb begin
    if (exp_ones)      cls = man_zero ? CLS_INF : CLS_NAN;
    else if (exp_zero) cls = man_zero ? CLS_ZERO : CLS_SUBN;
    else               cls = CLS_NORM;
  end
endmodule

// File: rtl/fpw_msb_find.sv
`timescale 1ns/1ps
module fpw_msb_find #(
  parameter int W   = 10,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          found
);
  // Priority encoder: the highest set bit wins.
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos   = PW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpw_pack.sv
`timescale 1ns/1ps
module fpw_pack
  import fpw_pkg::*;
#(
  parameter int EXP_IN  = 5,
  parameter int MAN_IN  = 10,
  parameter int EXP_OUT = 8,
  parameter int MAN_OUT = 23,
  localparam int OUT_W  = 1 + EXP_OUT + MAN_OUT,
  localparam int PW     = (MAN_IN > 1) ? $clog2(MAN_IN) : 1,
  localparam int SW     = $clog2(MAN_IN + 1),
  localparam int BIAS_I = (1 << (EXP_IN - 1)) - 1,
  localparam int BIAS_O = (1 << (EXP_OUT - 1)) - 1,
  localparam int REBIAS = BIAS_O - BIAS_I,
  localparam int PAD    = MAN_OUT - MAN_IN
) (
  input  logic               sign,
  input  logic [EXP_IN-1:0]  exp_f,
  input  logic [MAN_IN-1:0]  man_f,
  input  fpw_class_e         cls,
  input  logic [PW-1:0]      top_pos,
  output logic [OUT_W-1:0]   result
);
  logic [SW-1:0]      shamt;
  logic [MAN_IN-1:0]  sub_frac;
  logic [EXP_OUT-1:0] exp_norm;
  logic [EXP_OUT-1:0] exp_subn;
  logic [EXP_OUT-1:0] exp_o;
  logic [MAN_OUT-1:0] frac_o;

  // Shift that pushes the leading one just out of the mantissa field.
  assign shamt    = SW'(MAN_IN) - SW'(top_pos);
  assign sub_frac = man_f << shamt;
  assign exp_norm = EXP_OUT'(exp_f) + EXP_OUT'(REBIAS);
  assign exp_subn = EXP_OUT'(REBIAS + 1) - EXP_OUT'(shamt);

  always_comb begin
    exp_o  = '0;
    frac_o = '0;
    unique case (cls)
      CLS_ZERO: begin
        exp_o  = '0;
        frac_o = '0;
      end
      CLS_SUBN: begin
        exp_o  = exp_subn;
        frac_o = {sub_frac, {PAD{1'b0}}};
      end
      CLS_NORM: begin
        exp_o  = exp_norm;
        frac_o = {man_f, {PAD{1'b0}}};
      end
      CLS_INF: begin
        exp_o  = '1;
        frac_o = '0;
      end
      CLS_NAN: begin
        exp_o  = '1;
        frac_o = {1'b1, man_f[MAN_IN-2:0], {PAD{1'b0}}};
      end
      default: begin
        exp_o  = '0;
        frac_o = '0;
      end
    endcase
  end

  assign result = {sign, exp_o, frac_o};
endmodule

// File: rtl/fpw_half_widen.sv
`timescale 1ns/1ps
module fpw_half_widen
  import fpw_pkg::*;
#(
  parameter int EXP_IN  = 5,
  parameter int MAN_IN  = 10,
  parameter int EXP_OUT = 8,
  parameter int MAN_OUT = 23,
  localparam int IN_W   = 1 + EXP_IN + MAN_IN,
  localparam int OUT_W  = 1 + EXP_OUT + MAN_OUT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_half,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_word
);
  localparam int PW = (MAN_IN > 1) ? $clog2(MAN_IN) : 1;

  logic              u_sign;
  logic [EXP_IN-1:0] u_exp;
  logic [MAN_IN-1:0] u_man;
  fpw_class_e        u_cls;
  logic [PW-1:0]     u_pos;
  logic              u_found;
  logic [OUT_W-1:0]  u_result;

  fpw_unpack #(.EXP_IN(EXP_IN), .MAN_IN(MAN_IN)) u_unpack (
    .word  (in_half),
    .sign  (u_sign),
    .exp_f (u_exp),
    .man_f (u_man),
    .cls   (u_cls)
  );

  fpw_msb_find #(.W(MAN_IN)) u_msb (
    .vec   (u_man),
    .pos   (u_pos),
    .found (u_found)
  );

  fpw_pack #(
    .EXP_IN(EXP_IN), .MAN_IN(MAN_IN), .EXP_OUT(EXP_OUT), .MAN_OUT(MAN_OUT)
  ) u_pack (
    .sign    (u_sign),
    .exp_f   (u_exp),
    .man_f   (u_man),
    .cls     (u_cls),
    .top_pos (u_pos),
    .result  (u_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= u_result;
    end
  end
endmodule

// File: rtl/fpw_half_widen_chk.sv
`timescale 1ns/1ps
module fpw_half_widen_chk #(
  parameter int EXP_IN  = 5,
  parameter int MAN_IN  = 10,
  parameter int EXP_OUT = 8,
  parameter int MAN_OUT = 23,
  localparam int IN_W   = 1 + EXP_IN + MAN_IN,
  localparam int OUT_W  = 1 + EXP_OUT + MAN_OUT,
  localparam int REBIAS = ((1 << (EXP_OUT - 1)) - 1) - ((1 << (EXP_IN - 1)) - 1),
  localparam int PAD    = MAN_OUT - MAN_IN
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_half,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_word
);
  logic [EXP_IN-1:0]  i_exp;
  logic [MAN_IN-1:0]  i_man;
  logic [EXP_OUT-1:0] o_exp;
  logic [MAN_OUT-1:0] o_frac;

  assign i_exp  = in_half[IN_W-2 -: EXP_IN];
  assign i_man  = in_half[MAN_IN-1:0];
  assign o_exp  = out_word[OUT_W-2 -: EXP_OUT];
  assign o_frac = out_word[MAN_OUT-1:0];

  // R1
  a_r1_normal: assert property (@(posedge clk) disable iff (rst)
    (in_valid && i_exp != '0 && i_exp != '1) |=>
      (o_exp == EXP_OUT'($past(i_exp)) + EXP_OUT'(REBIAS)) &&
      (o_frac == {$past(i_man), {PAD{1'b0}}}));
  // R2
  a_r2_sign: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_word[OUT_W-1] == $past(in_half[IN_W-1]));
  // R3
  a_r3_nan_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && i_exp == '1 && i_man != '0) |=>
      (o_exp == '1) && o_frac[MAN_OUT-1] &&
      (o_frac[MAN_OUT-2 -: MAN_IN-1] == $past(i_man[MAN_IN-2:0])));
  // R4
  a_r4_inf: assert property (@(posedge clk) disable iff (rst)
    (in_valid && i_exp == '1 && i_man == '0) |=> (o_exp == '1) && (o_frac == '0));
  // R5
  a_r5_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && i_exp == '0 && i_man == '0) |=> (o_exp == '0) && (o_frac == '0));
  // R6
  a_r6_subnormal_range: assert property (@(posedge clk) disable iff (rst)
    (in_valid && i_exp == '0 && i_man != '0) |=>
      (o_exp <= EXP_OUT'(REBIAS)) && (o_exp >= EXP_OUT'(REBIAS + 1 - MAN_IN)) &&
      (o_frac[PAD-1:0] == '0));
  // R7
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));
  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word));
  // R9
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid && (out_word == '0));
endmodule

bind fpw_half_widen fpw_half_widen_chk #(
  .EXP_IN(EXP_IN), .MAN_IN(MAN_IN), .EXP_OUT(EXP_OUT), .MAN_OUT(MAN_OUT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_half   (in_half),
  .out_valid (out_valid),
  .out_word  (out_word)
);

// File: tb/fpw_half_widen_test.sv
`timescale 1ns/1ps
module fpw_half_widen_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] in_half;
  logic        out_valid;
  logic [31:0] out_word;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;

  always #4 clk = ~clk;

  fpw_half_widen uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
    .out_valid(out_valid), .out_word(out_word)
  );

  // Reference built from the numeric value of the operand.
  function automatic logic [31:0] ref_widen(logic [15:0] h);
    logic       s;
    int         e;
    int         m;
    int         k;
    logic [31:0] r;
    s = h[15];
    e = int'(h[14:10]);
    m = int'(h[9:0]);
    if (e == 31 && m == 0)      r = {s, 8'hFF, 23'd0};
    else if (e == 31)           r = {s, 8'hFF, 1'b1, h[8:0], 13'd0};
    else if (e == 0 && m == 0)  r = {s, 31'd0};
    else if (e == 0) begin
      k = 0;
      while ((1 << (k + 1)) <= m) k++;
      r = {s, 8'(103 + k), 23'((m - (1 << k)) << (23 - k))};
    end else                    r = {s, 8'(e + 112), h[9:0], 13'd0};
    return r;
  endfunction

  function automatic string tag_of(logic [15:0] h);
    string t;
    if (h[14:10] == 5'd31)      t = (h[9:0] == 0) ? "R4" : "R3";
    else if (h[14:10] == 5'd0)  t = (h[9:0] == 0) ? "R5" : "R6";
    else                        t = "R1";
    if (h[15]) t = {t, " R2"};
    return t;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] prev_h;
    bit          have;
    have     = 1'b0;
    prev_h   = '0;
    rst      = 1'b1;
    in_valid = 1'b0;
    in_half  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 valid", {31'd0, out_valid}, 32'd0);
    check("R9 word", out_word, 32'd0);
    rst = 1'b0;

    for (int v = 0; v < 65536; v++) begin
      @(negedge clk);
      if (have) begin
        check("R7 valid", {31'd0, out_valid}, 32'd1);
        check(tag_of(prev_h), out_word, ref_widen(prev_h));
      end
      in_half  = 16'(v);
      in_valid = 1'b1;
      prev_h   = 16'(v);
      have     = 1'b1;
      if (v % 4096 == 4095) begin
        @(negedge clk);
        check("R7 valid", {31'd0, out_valid}, 32'd1);
        check(tag_of(prev_h), out_word, ref_widen(prev_h));
        in_valid = 1'b0;
        for (int g = 0; g < 3; g++) begin
          in_half = ~prev_h ^ 16'(g);
          @(negedge clk);
          check("R7 idle", {31'd0, out_valid}, 32'd0);
          check("R8 hold", out_word, ref_widen(prev_h));
        end
        have = 1'b0;
      end
    end

    // Reset during traffic, then first result after it.
    in_valid = 1'b1;
    in_half  = 16'h3C00;
    rst      = 1'b1;
    @(negedge clk);
    check("R9 valid", {31'd0, out_valid}, 32'd0);
    check("R9 word", out_word, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R7 valid", {31'd0, out_valid}, 32'd1);
    check("R1", out_word, 32'h3F80_0000);
    in_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule